// File: doc/BRIEF.md
# Address Translation Cache

This block keeps a small fully associative store of finished virtual-to-physical translations in front of a page table walker. A lookup that matches a stored entry returns, in the same cycle, the physical address and the writable and user permission flags. A lookup that matches nothing raises a miss, which tells the walker to run. The walker then writes its result back through a fill port.

Each entry maps either a 4 KB page or a 4 MB page, and both sizes may be stored at the same time. Software keeps the cache consistent with its tables in two ways. It can remove the entry covering one virtual address, or it can pulse a strobe, tied to writes of the directory base register, that clears every entry at once. A walk result whose present bit is clear is never stored. Once every slot holds an entry, each new fill evicts one slot in rotating order.

Top module: `tlb_cache`

## Requirements
- R1: After reset no entry is valid, and every lookup reports a miss.
- R2: A lookup of a 4 KB entry hits when virtual bits 31:12 equal the stored page number. The physical address is then the stored 20-bit frame in bits 31:12 and the lookup's bits 11:0 in the low bits, and it appears in the same cycle as the lookup.
- R3: A lookup of a 4 MB entry hits when virtual bits 31:22 match. The physical address is then frame bits 19:10 in bits 31:22 and the lookup's bits 21:0 in the low bits. Addresses outside that 4 MB region miss.
- R4: A requested lookup that matches no valid entry drives lk_miss high and lk_hit low. The two outputs are never high together.
- R5: A fill whose present flag is 0 stores nothing.
- R6: An invalidate removes every entry whose page covers inv_vaddr, with coverage judged by the entry's own page size. Entries that do not cover it stay valid.
- R7: A pulse on base_wr makes every entry invalid from the next cycle on.
- R8: A fill is dropped when base_wr is high in the same cycle, or when an invalidate in the same cycle covers the fill's page.
- R9: The hit flags lk_wr and lk_user return the writable and user bits stored by the fill.
- R10: Fills go to the lowest-numbered free slot first. Once all slots are valid, the victim is chosen by a rotating pointer that starts at slot 0 after reset and advances by one on each such eviction.
- R11: A fill whose address matches an existing entry overwrites that entry in place, so a lookup never matches more than one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_miss | output | 1 | Lookup matched no entry |
| lk_paddr | output | 32 | Translated physical address |
| lk_wr | output | 1 | Writable flag of the matching entry |
| lk_user | output | 1 | User-access flag of the matching entry |
| fl_en | input | 1 | Fill strobe from the walker |
| fl_vaddr | input | 32 | Virtual address that was walked |
| fl_frame | input | 20 | Physical frame number (upper 10 bits used for 4 MB pages) |
| fl_big | input | 1 | 1 selects a 4 MB page, 0 a 4 KB page |
| fl_present | input | 1 | Present bit found by the walk |
| fl_wr | input | 1 | Writable bit found by the walk |
| fl_user | input | 1 | User bit found by the walk |
| inv_en | input | 1 | Single-address invalidate strobe |
| inv_vaddr | input | 32 | Address whose covering entry is removed |
| base_wr | input | 1 | Directory base written: clear all entries |

## Verification
Lookups are tried inside a page, at its last offset and just past its end, for both page sizes. This separates the 10-bit compare from the 20-bit compare and shows that the offset is spliced in at the right width. Invalidates are aimed at the far edge of a 4 MB page and at a neighbouring 4 KB page, which shows that coverage follows each entry's own size and that nothing else is removed. Fills are made to collide with an invalidate of the same page, with an invalidate of another page and with a flush, which tells the dropped case apart from the kept one. A ninth and tenth fill into a full store, together with a refill of a page already present, show which slot the rotation picks and that a refill replaces the old entry instead of adding a second one.

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_req,
  input  logic [31:0] lk_vaddr,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic [31:0] lk_paddr,
  output logic        lk_wr,
  output logic        lk_user,
  input  logic        fl_en,
  input  logic [31:0] fl_vaddr,
  input  logic [19:0] fl_frame,
  input  logic        fl_big,
  input  logic        fl_present,
  input  logic        fl_wr,
  input  logic        fl_user,
  input  logic        inv_en,
  input  logic [31:0] inv_vaddr,
  input  logic        base_wr
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] vld, big, wrb, usr;
  logic [19:0]  vpn [N];
  logic [19:0]  pfn [N];
  logic [N-1:0] lk_m, inv_m, fl_m;
  logic [IW-1:0] rr, slot;
  logic         drop, take, full;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign lk_m[g]  = vld[g] && (big[g] ? vpn[g][19:10] == lk_vaddr[31:22]
                                        : vpn[g] == lk_vaddr[31:12]);
    assign inv_m[g] = vld[g] && (big[g] ? vpn[g][19:10] == inv_vaddr[31:22]
                                        : vpn[g] == inv_vaddr[31:12]);
    assign fl_m[g]  = vld[g] && (big[g] ? vpn[g][19:10] == fl_vaddr[31:22]
                                        : vpn[g] == fl_vaddr[31:12]);
  end

  always_comb begin
    lk_paddr = '0;
    lk_wr    = 1'b0;
    lk_user  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (lk_m[i]) begin
        lk_paddr = big[i] ? {pfn[i][19:10], lk_vaddr[21:0]} : {pfn[i], lk_vaddr[11:0]};
        lk_wr    = wrb[i];
        lk_user  = usr[i];
      end
    end
  end

  assign lk_hit  = lk_req && (|lk_m);
  assign lk_miss = lk_req && !(|lk_m);

  assign drop = base_wr || (inv_en && (fl_big ? inv_vaddr[31:22] == fl_vaddr[31:22]
                                              : inv_vaddr[31:12] == fl_vaddr[31:12]));
  assign take = fl_en && fl_present && !drop;
  assign full = &vld;

  always_comb begin
    slot = rr;
    for (int i = N - 1; i >= 0; i--)
      if (!vld[i]) slot = IW'(i);
    for (int i = N - 1; i >= 0; i--)
      if (fl_m[i]) slot = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else begin
      if (base_wr)     vld <= '0;
      else if (inv_en) vld <= vld & ~inv_m;
      if (take) begin
        vld[slot] <= 1'b1;
        if (full && !(|fl_m))
          rr <= (rr == IW'(N - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      vpn[slot] <= fl_vaddr[31:12];
      pfn[slot] <= fl_frame;
      big[slot] <= fl_big;
      wrb[slot] <= fl_wr;
      usr[slot] <= fl_user;
    end
  end
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lk_req,
  input logic         lk_hit,
  input logic         lk_miss,
  input logic         fl_en,
  input logic         fl_present,
  input logic         inv_en,
  input logic         base_wr,
  input logic [N-1:0] vld,
  input logic [N-1:0] lk_m,
  input logic [N-1:0] inv_m
);
  assert_reset_empty_R1: assert property (@(posedge clk) !rst_n |=> vld == '0);

  assert_hit_miss_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> (lk_hit != lk_miss));

  assert_absent_not_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !fl_present && !inv_en && !base_wr) |=> vld == $past(vld));

  assert_inv_removes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !fl_en && !base_wr) |=> (vld & $past(inv_m)) == '0);

  assert_flush_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> vld == '0);

  assert_single_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> $countones(lk_m) <= 1);
endmodule

bind tlb_cache tlb_cache_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .fl_en(fl_en), .fl_present(fl_present), .inv_en(inv_en), .base_wr(base_wr),
  .vld(vld), .lk_m(lk_m), .inv_m(inv_m)
);

// File: tb/tlb_cache_tb_top.sv
module tlb_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic lk_hit, lk_miss, lk_wr, lk_user;
  logic [31:0] lk_paddr;
  logic fl_en = 1'b0, fl_big = 1'b0, fl_present = 1'b0, fl_wr = 1'b0, fl_user = 1'b0;
  logic [31:0] fl_vaddr = '0;
  logic [19:0] fl_frame = '0;
  logic inv_en = 1'b0;
  logic [31:0] inv_vaddr = '0;
  logic base_wr = 1'b0;
  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  tlb_cache dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_wr(lk_wr),
    .lk_user(lk_user), .fl_en(fl_en), .fl_vaddr(fl_vaddr), .fl_frame(fl_frame),
    .fl_big(fl_big), .fl_present(fl_present), .fl_wr(fl_wr), .fl_user(fl_user),
    .inv_en(inv_en), .inv_vaddr(inv_vaddr), .base_wr(base_wr)
  );

  task automatic look(input logic [31:0] va, input bit eh, input logic [31:0] ep,
                      input bit ew, input bit eu, input string req);
    @(negedge clk);
    lk_req = 1'b1;
    lk_vaddr = va;
    #1;
    total++;
    if (lk_hit !== eh || lk_miss !== !eh ||
        (eh && (lk_paddr !== ep || lk_wr !== ew || lk_user !== eu))) begin
      bad++;
      $display("FAIL %s va=%h got hit=%b miss=%b pa=%h w=%b u=%b exp hit=%b pa=%h w=%b u=%b",
               req, va, lk_hit, lk_miss, lk_paddr, lk_wr, lk_user, eh, ep, ew, eu);
    end
    lk_req = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] fr, input bit bg,
                      input bit pr, input bit w, input bit u);
    @(negedge clk);
    fl_en = 1'b1; fl_vaddr = va; fl_frame = fr; fl_big = bg;
    fl_present = pr; fl_wr = w; fl_user = u;
    @(negedge clk);
    fl_en = 1'b0;
  endtask

  task automatic inval(input logic [31:0] va);
    @(negedge clk);
    inv_en = 1'b1; inv_vaddr = va;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    base_wr = 1'b1;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic t_reset();
    look(32'h0000_0000, 0, 0, 0, 0, "R1");
    look(32'hC012_3456, 0, 0, 0, 0, "R1/R4");
  endtask

  task automatic t_sizes();
    fill(32'hC000_0000, 20'h12C00, 1, 1, 1, 0);
    fill(32'h0040_3000, 20'h00ABC, 0, 1, 1, 0);
    look(32'hC012_3456, 1, 32'h12D2_3456, 1, 0, "R3");
    look(32'hC03F_FFFF, 1, 32'h12FF_FFFF, 1, 0, "R3");
    look(32'hC040_0000, 0, 0, 0, 0, "R3/R4");
    look(32'h0040_3FFF, 1, 32'h00AB_CFFF, 1, 0, "R2/R9");
    look(32'h0040_4000, 0, 0, 0, 0, "R2/R4");
  endtask

  task automatic t_inval();
    inval(32'hC03F_FFFC);
    look(32'hC012_3456, 0, 0, 0, 0, "R6");
    look(32'h0040_3010, 1, 32'h00AB_C010, 1, 0, "R6");
    inval(32'h0040_4000);
    look(32'h0040_3010, 1, 32'h00AB_C010, 1, 0, "R6");
  endtask

  task automatic t_absent();
    fill(32'h0050_0000, 20'h00111, 0, 0, 1, 1);
    look(32'h0050_0000, 0, 0, 0, 0, "R5");
  endtask

  task automatic t_collide();
    @(negedge clk);
    fl_en = 1'b1; fl_vaddr = 32'h0060_0000; fl_frame = 20'h00222; fl_big = 1'b0;
    fl_present = 1'b1; fl_wr = 1'b0; fl_user = 1'b1;
    inv_en = 1'b1; inv_vaddr = 32'h0060_0123;
    @(negedge clk);
    fl_en = 1'b0; inv_en = 1'b0;
    look(32'h0060_0000, 0, 0, 0, 0, "R8");
    @(negedge clk);
    fl_en = 1'b1; fl_vaddr = 32'h0070_0000; fl_frame = 20'h00333;
    inv_en = 1'b1; inv_vaddr = 32'h0080_0000;
    @(negedge clk);
    fl_en = 1'b0; inv_en = 1'b0;
    look(32'h0070_0004, 1, 32'h0033_3004, 0, 1, "R8/R9");
    @(negedge clk);
    fl_en = 1'b1; fl_vaddr = 32'h0090_0000; fl_frame = 20'h00444;
    base_wr = 1'b1;
    @(negedge clk);
    fl_en = 1'b0; base_wr = 1'b0;
    look(32'h0090_0000, 0, 0, 0, 0, "R8");
    look(32'h0070_0004, 0, 0, 0, 0, "R7");
    look(32'h0040_3010, 0, 0, 0, 0, "R7");
  endtask

  task automatic t_refill();
    fill(32'h0040_3000, 20'h00ABC, 0, 1, 1, 0);
    fill(32'h0040_3000, 20'h00DEF, 0, 1, 0, 1);
    look(32'h0040_3008, 1, 32'h00DE_F008, 0, 1, "R11/R9");
    inval(32'h0040_3000);
    look(32'h0040_3008, 0, 0, 0, 0, "R11");
    flush();
  endtask

  task automatic t_rotate();
    for (int i = 0; i < 8; i++)
      fill(32'h0010_0000 + (i << 12), 20'h00500 + 20'(i), 0, 1, 1, 1);
    for (int i = 0; i < 8; i++)
      look(32'h0010_0000 + (i << 12), 1, {20'h00500 + 20'(i), 12'h000}, 1, 1, "R10");
    fill(32'h0020_0000, 20'h00600, 0, 1, 1, 1);
    look(32'h0010_0000, 0, 0, 0, 0, "R10");
    look(32'h0010_1000, 1, 32'h0050_1000, 1, 1, "R10");
    look(32'h0020_0000, 1, 32'h0060_0000, 1, 1, "R10");
    fill(32'h0020_1000, 20'h00601, 0, 1, 1, 1);
    look(32'h0010_1000, 0, 0, 0, 0, "R10");
    look(32'h0010_2000, 1, 32'h0050_2000, 1, 1, "R10");
    look(32'h0020_1000, 1, 32'h0060_1000, 1, 1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sizes();
    t_inval();
    t_absent();
    t_collide();
    t_refill();
    t_rotate();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule